// File: doc/BRIEF.md
# Driver Wake-up Mode Sequencer

This block is the mode controller of a bridge driver. It decides when the device leaves its low-power sleep state and when it reaches standby, where the bridge may be driven. Two events can start a wake-up. The first is the sleep-control pin staying high long enough to qualify. The second is a power-on-reset release pulse, which wakes the device whatever the pin is doing. After the wake event, two timed milestones follow. At the first, the device can communicate, and the active-low fault pin is pulled low to show it. At the second, initialization is complete.

What happens after initialization depends on the strap variant. A hardware-strapped device goes to standby on its own, unless its diagnostic level equals one reserved code. In that case it waits for a short low pulse on the sleep pin. A serial-configured device keeps the fault pin low until a clear-fault command has been decoded, then releases the pin and enters standby. The bridge is held in high impedance in every state other than standby. All time thresholds are parameters counted in clock cycles.

Top module: `drv_wake_seq`

## Requirements
- R1: After reset the state output is 0 (sleep), the high-impedance output is 1, the fault output is 1 and the communication-ready output is 0. The state codes are 0 sleep, 1 initializing, 2 waiting for clear-fault, 3 waiting for wake pulse, 4 standby.
- R2: In sleep, the sleep pin must be sampled high on QUAL_CYC+1 consecutive clock edges to begin waking, and the state becomes 1 at the last of those edges. A shorter high run clears the count, and the block stays in sleep with its outputs unchanged.
- R3: A power-on-reset release pulse sampled in sleep moves the state to 1 at that edge, whatever level the sleep pin has.
- R4: Communication-ready rises, and the fault output falls, COM_CYC clock edges after the state entered 1.
- R5: The state leaves 1 exactly RDY_CYC clock edges after it entered 1.
- R6: When the variant input is 0 (hardware-strapped) and the diagnostic input differs from HOLD_DIAG, the block goes from state 1 to standby. In standby the high-impedance output is 0 and the fault output is 1.
- R7: When the variant input is 0 and the diagnostic input equals HOLD_DIAG, the block goes from state 1 to state 3. A low on the sleep pin lasting 1 to PULSE_MAX-1 edges, followed by a high, gives standby at the edge where the high is sampled. A low lasting PULSE_MAX edges gives sleep.
- R8: When the variant input is 1 (serial-configured), the block goes from state 1 to state 2 and keeps the fault output low. A clear-fault pulse sampled in state 2 gives standby, with the fault output high, at that edge.
- R9: The high-impedance output is 1 in every state except standby.
- R10: A clear-fault pulse sampled in any state other than 2 has no effect on the state or the outputs.
- R11: A low sleep pin sampled in state 1, 2 or 4 returns the block to sleep at that edge. This holds even when a clear-fault pulse arrives in the same cycle. The exception is a wake caused by power-on reset: that source stays active until the sleep pin is first sampled high.
- R12: The parameters are checked at elaboration: RDY_CYC greater than COM_CYC, COM_CYC at least 1, PULSE_MAX at least 2.
- R13: A power-on-reset release pulse sampled outside sleep has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_pin_i | input | 1 | Sleep-control pin; high requests wake |
| por_rel_i | input | 1 | One-cycle pulse: supply power-on reset released |
| variant_i | input | 1 | 0 hardware-strapped, 1 serial-configured |
| diag_i | input | DIAG_W | Diagnostic level setting |
| clr_i | input | 1 | One-cycle pulse: clear-fault command decoded |
| fault_n_o | output | 1 | Active-low fault pin |
| hiz_o | output | 1 | Bridge high-impedance enable |
| st_o | output | 3 | State code |
| com_rdy_o | output | 1 | Communication-capable flag |

## Verification
The hardest case to reach is a power-on-reset wake with the sleep pin held low. It is the only way the block can get past initialization and sit in the clear-fault wait while the pin is low, so that it does not fall back to sleep. The stimulus keeps the pin low throughout such a wake. It adds stray clear-fault and reset-release pulses during initialization, then raises the pin once to retire the reset source before dropping it again. The wake-pulse window is driven on both sides of its limit: a two-cycle low and a low that lasts the whole window.

// File: rtl/drv_wake_pkg.sv
package drv_wake_pkg;
   typedef enum logic [2:0] {
      ST_SLEEP = 3'd0,
      ST_INIT  = 3'd1,
      ST_ACK   = 3'd2,
      ST_PULSE = 3'd3,
      ST_STBY  = 3'd4
   } wake_st_e;
endpackage

// File: rtl/drv_wake_qual.sv
// Counts consecutive high samples of the sleep pin while armed.
module drv_wake_qual #(
   parameter int QUAL_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic pin,
   output logic qual
);
   generate
      if (QUAL_CYC == 0) begin : g_direct
         assign qual = arm && pin;
      end else begin : g_count
         localparam int CW = $clog2(QUAL_CYC + 1);
         localparam logic [CW-1:0] LIM = CW'(QUAL_CYC);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (!arm || !pin)   cnt_q <= '0;
            else if (cnt_q != LIM)   cnt_q <= cnt_q + 1'b1;
         end
         assign qual = arm && pin && (cnt_q == LIM);
      end
   endgenerate
endmodule

// File: rtl/drv_wake_timer.sv
// Measures time spent in initialization and flags both milestones.
module drv_wake_timer #(
   parameter int COM_CYC = 3,
   parameter int RDY_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic com_reached,
   output logic rdy_hit
);
   localparam int TW = $clog2(RDY_CYC + 1);
   localparam logic [TW-1:0] COM_T = TW'(COM_CYC);
   localparam logic [TW-1:0] RDY_T = TW'(RDY_CYC);
   localparam logic [TW-1:0] RDY_M1 = TW'(RDY_CYC - 1);
   logic [TW-1:0] t_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            t_q <= '0;
      else if (!run)         t_q <= '0;
      else if (t_q != RDY_T) t_q <= t_q + 1'b1;
   end

   assign com_reached = run && (t_q >= COM_T);
   assign rdy_hit     = run && (t_q == RDY_M1);
endmodule

// File: rtl/drv_wake_pulse.sv
// Measures a low excursion of the sleep pin while waiting for the wake pulse.
module drv_wake_pulse #(
   parameter int PULSE_MAX = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic pin,
   output logic done,
   output logic tmo
);
   localparam int LW = $clog2(PULSE_MAX + 1);
   localparam logic [LW-1:0] LIM_M1 = LW'(PULSE_MAX - 1);
   logic [LW-1:0] low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_q <= '0;
      else if (!arm || pin) low_q <= '0;
      else if (low_q != LIM_M1) low_q <= low_q + 1'b1;
   end

   assign done = arm && pin && (low_q != '0);
   assign tmo  = arm && !pin && (low_q == LIM_M1);
endmodule

// File: rtl/drv_wake_seq.sv
module drv_wake_seq
   import drv_wake_pkg::*;
#(
   parameter int QUAL_CYC  = 4,
   parameter int COM_CYC   = 3,
   parameter int RDY_CYC   = 8,
   parameter int PULSE_MAX = 5,
   parameter int DIAG_W    = 3,
   parameter int HOLD_DIAG = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_pin_i,
   input  logic              por_rel_i,
   input  logic              variant_i,
   input  logic [DIAG_W-1:0] diag_i,
   input  logic              clr_i,
   output logic              fault_n_o,
   output logic              hiz_o,
   output logic [2:0]        st_o,
   output logic              com_rdy_o
);
   localparam logic [DIAG_W-1:0] HOLD_CODE = DIAG_W'(HOLD_DIAG);

   generate
      if (RDY_CYC <= COM_CYC || COM_CYC < 1 || PULSE_MAX < 2) begin : g_bad_cfg
         $error("drv_wake_seq: need RDY_CYC > COM_CYC >= 1 and PULSE_MAX >= 2");
      end
   endgenerate

   wake_st_e st_q, st_d;
   logic     por_src_q;
   logic     qual, com_reached, rdy_hit, pls_done, pls_tmo, drop;

   drv_wake_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n), .arm(st_q == ST_SLEEP),
      .pin(sleep_pin_i), .qual(qual)
   );

   drv_wake_timer #(.COM_CYC(COM_CYC), .RDY_CYC(RDY_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(st_q == ST_INIT),
      .com_reached(com_reached), .rdy_hit(rdy_hit)
   );

   drv_wake_pulse #(.PULSE_MAX(PULSE_MAX)) u_pulse (
      .clk(clk), .rst_n(rst_n), .arm(st_q == ST_PULSE),
      .pin(sleep_pin_i), .done(pls_done), .tmo(pls_tmo)
   );

   assign drop = !sleep_pin_i && !por_src_q &&
                 (st_q == ST_INIT || st_q == ST_ACK || st_q == ST_STBY);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_SLEEP: if (por_rel_i || qual) st_d = ST_INIT;
         ST_INIT:  if (rdy_hit) begin
                      if (variant_i)                st_d = ST_ACK;
                      else if (diag_i == HOLD_CODE) st_d = ST_PULSE;
                      else                          st_d = ST_STBY;
                   end
         ST_ACK:   if (clr_i) st_d = ST_STBY;
         ST_PULSE: if (pls_tmo) st_d = ST_SLEEP;
                   else if (pls_done) st_d = ST_STBY;
         ST_STBY:  st_d = ST_STBY;
         default:  st_d = ST_SLEEP;
      endcase
      if (drop) st_d = ST_SLEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_SLEEP;
         por_src_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_SLEEP)  por_src_q <= por_rel_i;
         else if (sleep_pin_i)  por_src_q <= 1'b0;
      end
   end

   assign st_o      = st_q;
   assign hiz_o     = (st_q != ST_STBY);
   assign com_rdy_o = (st_q == ST_INIT) ? com_reached : (st_q != ST_SLEEP);
   assign fault_n_o = !(com_rdy_o && st_q != ST_STBY);
endmodule

// File: rtl/drv_wake_chk.sv
module drv_wake_chk #(
   parameter int DIAG_W    = 3,
   parameter int HOLD_DIAG = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep_pin_i,
   input logic              por_rel_i,
   input logic              variant_i,
   input logic [DIAG_W-1:0] diag_i,
   input logic              clr_i,
   input logic              fault_n_o,
   input logic              hiz_o,
   input logic [2:0]        st_o,
   input logic              com_rdy_o,
   input logic              por_src
);
   a_r2_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      (st_o == 3'd0 && !sleep_pin_i && !por_rel_i) |=> (st_o == 3'd0));

   a_r3_por_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (st_o == 3'd0 && por_rel_i) |=> (st_o == 3'd1 && hiz_o));

   a_r4_fault_needs_com: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_n_o |-> com_rdy_o);

   a_r6_auto_standby: assert property (@(posedge clk) disable iff (!rst_n)
      (st_o == 3'd4 && $past(st_o) == 3'd1) |->
         (!$past(variant_i) && $past(diag_i) != DIAG_W'(HOLD_DIAG)));

   a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
      (st_o == 3'd2 && clr_i && sleep_pin_i) |=> (st_o == 3'd4 && fault_n_o && !hiz_o));

   a_r10_early_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (st_o == 3'd1 && clr_i && variant_i) |=> (st_o != 3'd4));

   a_r11_drop_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_pin_i && !por_src && (st_o == 3'd1 || st_o == 3'd2 || st_o == 3'd4))
         |=> (st_o == 3'd0 && hiz_o && fault_n_o));
endmodule

bind drv_wake_seq drv_wake_chk #(.DIAG_W(DIAG_W), .HOLD_DIAG(HOLD_DIAG)) u_chk (
   .clk(clk), .rst_n(rst_n), .sleep_pin_i(sleep_pin_i), .por_rel_i(por_rel_i),
   .variant_i(variant_i), .diag_i(diag_i), .clr_i(clr_i), .fault_n_o(fault_n_o),
   .hiz_o(hiz_o), .st_o(st_o), .com_rdy_o(com_rdy_o), .por_src(por_src_q)
);

// File: tb/drv_wake_seq_tb.sv
module drv_wake_seq_tb;
   localparam int Q = 4, C = 3, R = 8, P = 5, DW = 3, H = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic pin = 1'b0, por = 1'b0, vsel = 1'b0, clr = 1'b0;
   logic [DW-1:0] diag = '0;
   logic fault_n, hiz, com_rdy;
   logic [2:0] st;

   int n_cmp = 0, n_bad = 0;
   string phase = "R1";
   bit done = 1'b0;

   always #2 clk = ~clk;

   drv_wake_seq #(.QUAL_CYC(Q), .COM_CYC(C), .RDY_CYC(R), .PULSE_MAX(P),
                  .DIAG_W(DW), .HOLD_DIAG(H)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_pin_i(pin), .por_rel_i(por),
      .variant_i(vsel), .diag_i(diag), .clr_i(clr), .fault_n_o(fault_n),
      .hiz_o(hiz), .st_o(st), .com_rdy_o(com_rdy)
   );

   // behavioural reference model
   int m_st = 0, m_hi = 0, m_t = 0, m_low = 0;
   bit m_por = 0;
   always @(posedge clk) begin
      int nst;
      if (!rst_n) begin
         m_st = 0; m_hi = 0; m_t = 0; m_low = 0; m_por = 0;
      end else begin
         nst = m_st;
         if (m_st == 0) begin
            if (por) begin nst = 1; m_por = 1; end
            else if (pin) begin m_hi++; if (m_hi > Q) nst = 1; end
            else m_hi = 0;
         end else begin
            if (m_st == 1) begin
               m_t++;
               if (m_t == R) nst = vsel ? 2 : ((int'(diag) == H) ? 3 : 4);
            end
            if (m_st == 2 && clr) nst = 4;
            if (m_st == 3) begin
               if (!pin) begin m_low++; if (m_low == P) nst = 0; end
               else if (m_low > 0) nst = 4;
            end
            if (!pin && !m_por && m_st != 3) nst = 0;
            if (pin) m_por = 0;
         end
         if (nst != m_st) begin
            m_hi = 0; m_t = 0; m_low = 0;
            if (nst == 0) m_por = 0;
         end
         m_st = nst;
      end
   end

   task automatic cmp(input int got, input int exp, input string what);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d at %0t", phase, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e_com;
         e_com = (m_st != 0) && (m_st != 1 || m_t >= C);
         cmp(int'(st), m_st, "state");
         cmp(int'(hiz), int'(m_st != 4), "hiz (R9)");
         cmp(int'(com_rdy), int'(e_com), "com_rdy");
         cmp(int'(fault_n), int'(!(e_com && m_st != 4)), "fault_n");
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_por();
      por = 1'b1; step(1); por = 1'b0;
   endtask

   task automatic pulse_clr();
      clr = 1'b1; step(1); clr = 1'b0;
   endtask

   task automatic spot(input int got, input int exp, input string tag);
      string keep;
      keep = phase; phase = tag;
      cmp(got, exp, "spot");
      phase = keep;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      phase = "R1";
      spot(int'(st), 0, "R1"); spot(int'(hiz), 1, "R1");
      spot(int'(fault_n), 1, "R1"); spot(int'(com_rdy), 0, "R1");

      // R12: legal parameter set used by this bench
      spot(int'(R > C && C >= 1 && P >= 2), 1, "R12");

      phase = "R2";                 // short high run
      pin = 1'b1; step(Q); pin = 1'b0; step(2);
      spot(int'(st), 0, "R2");
      pin = 1'b1; step(Q + 1);      // qualified wake
      spot(int'(st), 1, "R2");
      phase = "R4";
      step(C - 1); spot(int'(com_rdy), 0, "R4");
      step(1);     spot(int'(fault_n), 0, "R4");
      phase = "R5";
      step(R - C - 1); spot(int'(st), 1, "R5");
      step(1); spot(int'(st), 4, "R6"); spot(int'(hiz), 0, "R6");
      step(3);
      phase = "R11";
      pin = 1'b0; step(1); spot(int'(st), 0, "R11");
      step(2);

      phase = "R3";                 // power-on wake, pin low, serial variant
      vsel = 1'b1; pulse_por(); spot(int'(st), 1, "R3");
      phase = "R10"; pulse_clr(); spot(int'(st), 1, "R10");
      phase = "R13"; pulse_por(); spot(int'(st), 1, "R13");
      step(R); spot(int'(st), 2, "R8"); spot(int'(fault_n), 0, "R8");
      phase = "R11"; step(3); spot(int'(st), 2, "R11");
      phase = "R8"; pulse_clr(); spot(int'(st), 4, "R8"); spot(int'(fault_n), 1, "R8");
      phase = "R11"; step(2); spot(int'(st), 4, "R11");
      pin = 1'b1; step(1); pin = 1'b0; step(1); spot(int'(st), 0, "R11");

      phase = "R7";                 // reserved diagnostic level
      vsel = 1'b0; diag = DW'(H);
      pin = 1'b1; step(Q + 1 + R); spot(int'(st), 3, "R7");
      phase = "R10"; pulse_clr(); spot(int'(st), 3, "R10");
      phase = "R7";
      pin = 1'b0; step(2); pin = 1'b1; step(1); spot(int'(st), 4, "R7");
      pin = 1'b0; step(2); pin = 1'b1;
      step(Q + 1 + R); spot(int'(st), 3, "R7");
      pin = 1'b0; step(P); spot(int'(st), 0, "R7");
      step(2);

      phase = "R11";                // drop beats clear-fault
      vsel = 1'b1; diag = '0;
      pin = 1'b1; step(Q + 1 + R); spot(int'(st), 2, "R8");
      pin = 1'b0; clr = 1'b1; step(1); clr = 1'b0;
      spot(int'(st), 0, "R11");
      step(3);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule